// File: doc/BRIEF.md
# Time-Multiplexed Wavetable Voice Engine

This block produces audio from up to eight wavetable voices using one shared 128-byte RAM. Each voice owns an 8-byte register group in that RAM, holding a frequency step, a running phase, a wave length code, a wave base offset and a volume. The packed 4-bit waveform samples sit in the same RAM. On each one-cycle tick pulse the engine serves one voice. It reads that voice's registers and fetches one sample nibble. It scales the sample by the volume, advances the phase and writes the new phase back into RAM. It then moves on to the next lower register group.

Two output styles are available. In the interleaved style the output is the current voice's scaled sample, refreshed on every tick. In the averaged style the scaled samples are summed over one full round of active voices, and the output is refreshed once per round with that sum divided by the voice count. A control write sets the output style and a sound-off flag. A host port reaches the RAM through an address latch that can step forward by itself after each access.

Top module: `wavetable_voice_engine`

## Requirements
- R1: After reset the output is 0 and every RAM byte reads 0. The voice pointer is 0x78, the interleaved style is selected and sound is on.
- R2: A latch write (`host_latch_we`) loads the address from `host_wdata[6:0]` and the step flag from `host_wdata[7]`. After a RAM read or write with `host_cpu`=1 and the flag set, the address steps by one modulo 128. Without either condition the address is unchanged.
- R3: A host write stores `host_wdata` at the latched address. A host read presents that byte on `host_rdata` one clock later.
- R4: Voice group layout at base B: frequency = {B+4 bits 1:0, B+2, B+0} (18 bits). Phase = {B+5, B+3, B+1} (24 bits). Length = 256 - (B+4 AND 0xFC). Wave base = B+6. Volume = B+7 bits 3:0.
- R5: Sample address = (wave base + phase bits 23:16) mod 256. The sample is the low nibble of RAM byte (address >> 1) when address bit 0 is 0, and the high nibble when it is 1. The voice value = (nibble - 8) * volume, signed.
- R6: On each served tick the phase becomes (phase + frequency) mod 2^24. If bits 23:16 of that sum are >= length, only its low 18 bits are kept. The result is written back to B+1, B+3 and B+5.
- R7: Voices are served from base 0x78 downward in steps of 8. With N = bits 6:4 of byte 0x7F, once base 0x78-8N has been served the pointer reloads to 0x78, so N+1 voices are active.
- R8: In the interleaved style (`cfg_mux`=1) the output after each served tick is that tick's voice value.
- R9: In the averaged style the voice values are summed over a round. The output changes only at the tick that completes the round, to the sum divided by N+1, truncated toward zero, and the sum then restarts from zero.
- R10: With sound off (`cfg_disable`=1) a tick forces the output to 0 in both styles. It leaves the phase and the voice pointer unchanged.
- R11: When a host write and a phase write-back hit the same byte in one cycle, the host value is kept.
- R12: The output changes only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse: serve one voice |
| cfg_we | input | 1 | Load the control flags |
| cfg_disable | input | 1 | Sound off flag, loaded by cfg_we |
| cfg_mux | input | 1 | 1 = interleaved output, 0 = averaged output, loaded by cfg_we |
| host_latch_we | input | 1 | Load the address latch from host_wdata |
| host_wr | input | 1 | Write host_wdata into RAM at the latched address |
| host_rd | input | 1 | Read RAM at the latched address |
| host_cpu | input | 1 | Access counts as processor access (allows stepping) |
| host_wdata | input | 8 | Latch value or write data |
| host_rdata | output | 8 | Read data, valid one clock after host_rd |
| audio_out | output | OUT_W (13) | Signed audio sample |

## Verification
The bench sweeps every nibble value against every volume, for both nibble halves. The unused nibble is filled with its complement, so a swapped nibble select or an unsigned product gives wrong values. A phase sweep crosses frequencies and length codes and reads the phase back after every tick. A design that cleared the whole phase on a wrap, compared against the wrong bits or dropped the frequency's top bits would drift from the reference. A round with a negative sum that does not divide evenly exposes division that rounds down instead of toward zero. Interleaved runs over four voices expose a wrong service order. A tick issued together with a host write to a phase byte shows whether the engine can overwrite the host. Sound-off ticks check that the output goes to zero and that the phase stops advancing.

// File: rtl/wte_pkg.sv
package wte_pkg;
    localparam int BYTE_W      = 8;
    localparam int FREQ_W      = 18;
    localparam int PHASE_W     = 24;
    localparam int LEN_W       = 9;
    localparam int VOL_W       = 4;
    localparam int NIB_W       = 4;
    localparam int GROUP_BYTES = 8;
    localparam int PROD_W      = 10;
    // byte offsets inside one voice group
    localparam int OFS_FRQ_L = 0;
    localparam int OFS_PHS_L = 1;
    localparam int OFS_FRQ_M = 2;
    localparam int OFS_PHS_M = 3;
    localparam int OFS_LEN   = 4;
    localparam int OFS_PHS_H = 5;
    localparam int OFS_BASE  = 6;
    localparam int OFS_VOL   = 7;
    // position of the active-voice field in the last RAM byte
    localparam int CNT_LSB   = 4;
    // address latch step flag position
    localparam int STEP_BIT  = 7;
endpackage

// File: rtl/wte_addr_latch.sv
module wte_addr_latch
    import wte_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_we,
    input  logic [BYTE_W-1:0] latch_data,
    input  logic              access,
    input  logic              cpu,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              step;
    } latch_t;

    latch_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (latch_we) begin
            lat_d.addr = latch_data[ADDR_W-1:0];
            lat_d.step = latch_data[STEP_BIT];
        end else if (access && cpu && lat_q.step) begin
            lat_d.addr = lat_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign addr = lat_q.addr;
endmodule

// File: rtl/wte_ram.sv
module wte_ram
    import wte_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [BYTE_W-1:0]             host_wdata,
    input  logic                          eng_we,
    input  logic [ADDR_W-1:0]             eng_base,
    input  logic [PHASE_W-1:0]            eng_phase,
    output logic [DEPTH-1:0][BYTE_W-1:0]  mem_q
);
    logic [DEPTH-1:0][BYTE_W-1:0] mem_d;

    always_comb begin
        mem_d = mem_q;
        if (eng_we) begin
            mem_d[eng_base + ADDR_W'(OFS_PHS_L)] = eng_phase[7:0];
            mem_d[eng_base + ADDR_W'(OFS_PHS_M)] = eng_phase[15:8];
            mem_d[eng_base + ADDR_W'(OFS_PHS_H)] = eng_phase[23:16];
        end
        // host write is applied last so it wins a collision
        if (host_we) mem_d[host_addr] = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/wte_voice_calc.sv
module wte_voice_calc
    import wte_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0][BYTE_W-1:0] mem,
    input  logic [ADDR_W-1:0]            base,
    output logic signed [PROD_W-1:0]     product,
    output logic [PHASE_W-1:0]           phase_next
);
    logic [GROUP_BYTES-1:0][BYTE_W-1:0] grp;

    for (genvar k = 0; k < GROUP_BYTES; k++) begin : g_grp
        assign grp[k] = mem[base + ADDR_W'(k)];
    end

    logic [FREQ_W-1:0]        freq;
    logic [PHASE_W-1:0]       phase;
    logic [LEN_W-1:0]         wave_len;
    logic [ADDR_W:0]          samp_addr;
    logic [BYTE_W-1:0]        samp_byte;
    logic [NIB_W-1:0]         nib;
    logic [VOL_W-1:0]         vol;
    logic signed [PROD_W-1:0] wave_s;
    logic signed [PROD_W-1:0] vol_s;
    logic [PHASE_W-1:0]       phase_sum;
    logic [3:0]               unused_vol_hi;

    assign unused_vol_hi = grp[OFS_VOL][7:4];

    always_comb begin
        freq      = {grp[OFS_LEN][1:0], grp[OFS_FRQ_M], grp[OFS_FRQ_L]};
        phase     = {grp[OFS_PHS_H], grp[OFS_PHS_M], grp[OFS_PHS_L]};
        wave_len  = LEN_W'(256) - {1'b0, grp[OFS_LEN] & 8'hFC};
        samp_addr = (ADDR_W+1)'(grp[OFS_BASE]) + (ADDR_W+1)'(phase[PHASE_W-1 -: 8]);
        samp_byte = mem[samp_addr[ADDR_W:1]];
        nib       = samp_addr[0] ? samp_byte[7:4] : samp_byte[3:0];
        vol       = grp[OFS_VOL][VOL_W-1:0];
        wave_s    = $signed(PROD_W'(nib)) - $signed(PROD_W'(8));
        vol_s     = $signed(PROD_W'(vol));
        product   = wave_s * vol_s;

        phase_sum = phase + PHASE_W'(freq);
        if ({1'b0, phase_sum[PHASE_W-1 -: 8]} >= wave_len)
            phase_next = {{(PHASE_W-FREQ_W){1'b0}}, phase_sum[FREQ_W-1:0]};
        else
            phase_next = phase_sum;
    end
endmodule

// File: rtl/wavetable_voice_engine.sv
module wavetable_voice_engine
    import wte_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int VOICES = 8,
    parameter int OUT_W  = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    cfg_we,
    input  logic                    cfg_disable,
    input  logic                    cfg_mux,
    input  logic                    host_latch_we,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic                    host_cpu,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    output logic signed [OUT_W-1:0] audio_out
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int TOP_BASE = DEPTH - GROUP_BYTES;
    localparam int CNT_W    = $clog2(VOICES);
    localparam int PTR_X    = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [OUT_W-1:0]  acc;
        logic [OUT_W-1:0]  out;
        logic              dis;
        logic              mux;
        logic [7:0]        rdata;
    } eng_state_t;

    localparam eng_state_t RESET_ST = '{
        ptr:   ADDR_W'(TOP_BASE),
        acc:   '0,
        out:   '0,
        dis:   1'b0,
        mux:   1'b1,
        rdata: 8'h00
    };

    eng_state_t st_d, st_q;

    logic [ADDR_W-1:0]            host_addr;
    logic [DEPTH-1:0][BYTE_W-1:0] mem_q;
    logic signed [PROD_W-1:0]     product;
    logic [PHASE_W-1:0]           phase_next;
    logic                         eng_we;
    logic [CNT_W-1:0]             act_cnt;
    logic [PTR_X-1:0]             last_base;
    logic signed [OUT_W-1:0]      acc_sum;
    logic signed [OUT_W-1:0]      divisor;
    logic                         flush;

    wte_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_we   (host_latch_we),
        .latch_data (host_wdata),
        .access     (host_wr | host_rd),
        .cpu        (host_cpu),
        .addr       (host_addr)
    );

    wte_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .eng_we     (eng_we),
        .eng_base   (st_q.ptr),
        .eng_phase  (phase_next),
        .mem_q      (mem_q)
    );

    wte_voice_calc #(.ADDR_W(ADDR_W)) u_calc (
        .mem        (mem_q),
        .base       (st_q.ptr),
        .product    (product),
        .phase_next (phase_next)
    );

    always_comb begin
        st_d      = st_q;
        eng_we    = 1'b0;
        flush     = 1'b0;
        act_cnt   = mem_q[DEPTH-1][CNT_LSB +: CNT_W];
        last_base = PTR_X'(TOP_BASE) - PTR_X'({act_cnt, 3'b000});
        acc_sum   = $signed(st_q.acc) + $signed(OUT_W'(product));
        divisor   = st_q.mux ? $signed(OUT_W'(1))
                             : $signed(OUT_W'(act_cnt) + OUT_W'(1));

        if (cfg_we) begin
            st_d.dis = cfg_disable;
            st_d.mux = cfg_mux;
        end

        if (host_rd) st_d.rdata = mem_q[host_addr];

        if (tick_en) begin
            if (st_q.mux) st_d.out = '0;
            if (st_q.dis) begin
                st_d.out = '0;
            end else begin
                eng_we = 1'b1;
                flush  = st_q.mux;
                if ({1'b0, st_q.ptr} < last_base + PTR_X'(GROUP_BYTES)) begin
                    st_d.ptr = ADDR_W'(TOP_BASE);
                    flush    = 1'b1;
                end else begin
                    st_d.ptr = st_q.ptr - ADDR_W'(GROUP_BYTES);
                end
                if (flush) begin
                    st_d.out = acc_sum / divisor;
                    st_d.acc = '0;
                end else begin
                    st_d.acc = acc_sum;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
    assign audio_out  = $signed(st_q.out);
endmodule

// File: rtl/wte_checker.sv
module wte_checker #(
    parameter int ADDR_W = 7,
    parameter int OUT_W  = 13,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick_en,
    input logic                   host_wr,
    input logic                   host_latch_we,
    input logic [7:0]             host_wdata,
    input logic [ADDR_W-1:0]      host_addr,
    input logic                   dis,
    input logic [ADDR_W-1:0]      ptr,
    input logic [OUT_W-1:0]       audio_out,
    input logic [DEPTH-1:0][7:0]  mem
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 8);

    // R10
    off_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && dis) |=> (audio_out == '0) && $stable(ptr));

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !dis) |=> (ptr == ADDR_W'($past(ptr) - ADDR_W'(8))) || (ptr == TOP));

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(audio_out));

    // R11
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> mem[$past(host_addr)] == $past(host_wdata));

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_latch_we |=> host_addr == $past(host_wdata[ADDR_W-1:0]));
endmodule

bind wavetable_voice_engine wte_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .host_wr       (host_wr),
    .host_latch_we (host_latch_we),
    .host_wdata    (host_wdata),
    .host_addr     (host_addr),
    .dis           (st_q.dis),
    .ptr           (st_q.ptr),
    .audio_out     (audio_out),
    .mem           (mem_q)
);

// File: tb/wavetable_voice_engine_test.sv
`timescale 1ns/1ps
module wavetable_voice_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_disable = 1'b0;
    logic        cfg_mux = 1'b0;
    logic        host_latch_we = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_cpu = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic signed [12:0] audio_out;

    int n_chk = 0;
    int n_bad = 0;

    wavetable_voice_engine uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cfg_we(cfg_we), .cfg_disable(cfg_disable), .cfg_mux(cfg_mux),
        .host_latch_we(host_latch_we), .host_wr(host_wr), .host_rd(host_rd),
        .host_cpu(host_cpu), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .audio_out(audio_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input longint got, input longint exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_latch(input logic [7:0] v);
        host_latch_we = 1'b1; host_wdata = v;
        @(negedge clk);
        host_latch_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input logic cpu);
        host_wr = 1'b1; host_cpu = cpu; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_cpu = 1'b0;
    endtask

    task automatic rd(input logic cpu, output logic [7:0] d);
        host_rd = 1'b1; host_cpu = cpu;
        @(negedge clk);
        host_rd = 1'b0; host_cpu = 1'b0;
        d = host_rdata;
    endtask

    task automatic poke(input int a, input int d);
        set_latch({1'b0, 7'(a)});
        wr(8'(d), 1'b0);
    endtask

    task automatic peek(input int a, output logic [7:0] d);
        set_latch({1'b0, 7'(a)});
        rd(1'b0, d);
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic cfg(input logic dis, input logic mux);
        cfg_we = 1'b1; cfg_disable = dis; cfg_mux = mux;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_voice(input int b, input int fr, input int ph,
                             input int lc, input int ofs, input int volb);
        poke(b + 0, fr & 'hFF);
        poke(b + 2, (fr >> 8) & 'hFF);
        poke(b + 4, (lc & 'hFC) | ((fr >> 16) & 3));
        poke(b + 1, ph & 'hFF);
        poke(b + 3, (ph >> 8) & 'hFF);
        poke(b + 5, (ph >> 16) & 'hFF);
        poke(b + 6, ofs);
        poke(b + 7, volb);
    endtask

    task automatic read_phase(output int ph);
        logic [7:0] lo, mi, hi;
        peek('h79, lo); peek('h7B, mi); peek('h7D, hi);
        ph = {8'h00, hi, mi, lo};
    endtask

    function automatic int ph_step(input int ph, input int fr, input int len);
        int s;
        s = (ph + fr) & 'hFFFFFF;
        if ((s >> 16) >= len) s = s & 'h3FFFF;
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int ph;
        int nv[8];
        int vv[8];
        int sum;
        int held;

        // ---------------- R1 reset state
        do_reset();
        check("R1 output after reset", audio_out, 0);
        peek('h7F, d); check("R1 ram 0x7F cleared", d, 0);
        peek('h00, d); check("R1 ram 0x00 cleared", d, 0);
        // interleaved style by default: N=1, first tick already outputs
        poke('h00, 'h0F);                    // nibble 15 at sample addr 0
        poke('h7F, 'h10 | 3);                // N=1, volume 3
        tick();
        check("R1 R8 default interleaved output", audio_out, 7 * 3);

        // ---------------- R2 R3 address latch and host access
        do_reset();
        set_latch(8'h80 | 8'h7E);
        wr(8'h11, 1'b1); wr(8'h22, 1'b1); wr(8'h33, 1'b1);
        set_latch(8'h80 | 8'h10);
        wr(8'h44, 1'b0); wr(8'h55, 1'b0);    // not processor: no stepping
        set_latch(8'h20);
        wr(8'h66, 1'b1); wr(8'h77, 1'b1);    // flag clear: no stepping
        peek('h7E, d); check("R3 write at 0x7E", d, 'h11);
        peek('h7F, d); check("R2 step to 0x7F", d, 'h22);
        peek('h00, d); check("R2 wrap to 0x00", d, 'h33);
        peek('h10, d); check("R2 no step without cpu", d, 'h55);
        peek('h11, d); check("R2 no step without cpu (next byte)", d, 0);
        peek('h20, d); check("R2 no step without flag", d, 'h77);
        peek('h21, d); check("R2 no step without flag (next byte)", d, 0);
        set_latch(8'h80 | 8'h7E);
        rd(1'b1, d); check("R3 read stepping 0x7E", d, 'h11);
        rd(1'b1, d); check("R3 read stepping 0x7F", d, 'h22);
        rd(1'b1, d); check("R3 read stepping 0x00", d, 'h33);

        // ---------------- R5 R8 exhaustive nibble x volume sweep
        do_reset();
        for (int nib = 0; nib < 16; nib++) begin
            for (int vol = 0; vol < 16; vol++) begin
                for (int half = 0; half < 2; half++) begin
                    if (half == 1) poke('h10, (nib << 4) | (15 - nib));
                    else           poke('h10, ((15 - nib) << 4) | nib);
                    poke('h7F, vol);
                    poke('h7E, 'h20 | half);
                    tick();
                    check("R5 R8 scaled sample", audio_out, (nib - 8) * vol);
                end
            end
        end
        // phase high byte adds to the base with 8-bit wrap: F0 + 21 = 0x11
        do_reset();
        poke('h08, 'hC3);                     // high nibble C
        set_voice('h78, 0, 'h210000, 0, 'hF0, 9);
        tick();
        check("R5 base plus phase wraps", audio_out, (12 - 8) * 9);

        // ---------------- R4 R6 phase advance and wrap
        do_reset();
        begin
            int fr_l[4];
            int lc_l[3];
            fr_l = '{'h00400, 'h18000, 'h3FFFF, 'h01234};
            lc_l = '{'hFC, 'h80, 'h00};
            for (int f = 0; f < 4; f++) begin
                for (int l = 0; l < 3; l++) begin
                    int exp_ph;
                    int len;
                    len = 256 - lc_l[l];
                    exp_ph = 'h0300FF;
                    set_voice('h78, fr_l[f], exp_ph, lc_l[l], 0, 0);
                    for (int t = 0; t < 8; t++) begin
                        tick();
                        exp_ph = ph_step(exp_ph, fr_l[f], len);
                        read_phase(ph);
                        check("R4 R6 phase write-back", ph, exp_ph);
                    end
                end
            end
        end

        // ---------------- R7 service order, R9 averaged output
        do_reset();
        nv = '{0, 3, 9, 8, 0, 0, 0, 0};
        vv = '{15, 7, 2, 5, 0, 0, 0, 0};
        for (int k = 0; k < 4; k++) begin
            poke(k, nv[k]);
            set_voice('h78 - 8 * k, 0, 0, 0, 2 * k, (k == 0) ? ('h30 | vv[0]) : vv[k]);
        end
        for (int t = 0; t < 8; t++) begin
            tick();
            check("R7 R8 interleaved voice order", audio_out,
                  (nv[t % 4] - 8) * vv[t % 4]);
        end
        cfg(1'b0, 1'b0);
        held = audio_out;
        sum = 0;
        for (int k = 0; k < 4; k++) sum += (nv[k] - 8) * vv[k];
        for (int t = 0; t < 3; t++) begin
            tick();
            check("R9 R12 output held mid-round", audio_out, held);
        end
        tick();
        check("R9 average truncates toward zero", audio_out, sum / 4);
        // full eight-voice round
        nv = '{15, 12, 10, 9, 15, 13, 11, 15};
        vv = '{15, 14, 13, 12, 11, 10, 9, 8};
        for (int k = 0; k < 8; k++) begin
            poke(k, nv[k]);
            set_voice('h78 - 8 * k, 0, 0, 0, 2 * k, (k == 0) ? ('h70 | vv[0]) : vv[k]);
        end
        sum = 0;
        for (int k = 0; k < 8; k++) sum += (nv[k] - 8) * vv[k];
        held = audio_out;
        for (int t = 0; t < 7; t++) tick();
        check("R9 R12 held before round ends", audio_out, held);
        tick();
        check("R7 R9 eight-voice average", audio_out, sum / 8);
        tick();
        check("R9 sum restarts after round", audio_out, sum / 8);

        // ---------------- R10 sound off
        do_reset();
        poke('h00, 'h0F);
        set_voice('h78, 'h10000, 0, 0, 0, 5);
        tick();
        check("R10 baseline output", audio_out, 7 * 5);
        cfg(1'b1, 1'b1);
        tick();
        check("R10 interleaved off output", audio_out, 0);
        read_phase(ph);
        check("R10 phase frozen", ph, 'h010000);
        cfg(1'b0, 1'b1);
        tick();
        check("R10 resumes at next sample", audio_out, (0 - 8) * 5);
        cfg(1'b1, 1'b0);
        tick();
        check("R10 averaged off output", audio_out, 0);
        read_phase(ph);
        check("R10 phase frozen in averaged style", ph, 'h020000);

        // ---------------- R11 host write beats phase write-back
        do_reset();
        poke('h7A, 'h01);                     // frequency 0x100
        set_latch(8'h79);
        host_wr = 1'b1; host_wdata = 8'hAB; host_cpu = 1'b0; tick_en = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; tick_en = 1'b0;
        peek('h79, d); check("R11 host value kept", d, 'hAB);
        peek('h7B, d); check("R11 engine middle byte written", d, 'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule